// File: doc/BRIEF.md
# Receive Polarity Correction Controller

This block decides whether the receive twisted pair of a 10 Mb/s port has been wired with its two conductors swapped, and undoes the swap before the data reaches the Manchester decoder. It works on the digital output of the slicer. The slicer marks two events: the moment a link pulse is seen (`lp_i`) and the moment the end-of-frame idle pulse is seen (`eof_i`). On each marker the block samples the sliced level. A correctly wired pair shows a high level there, and a swapped pair shows a low level. The same correction covers normal frame reception and the pulses exchanged during auto-negotiation.

Two register bits control the block. The mode bit chooses between automatic and manual operation. The meaning of the polarity bit depends on the mode. In automatic mode it is a read-only view of the detector's current decision. In manual mode it is a writable bit that forces the inversion. The corrected stream `rx_data_o` is the raw sliced bit XORed with the effective polarity flag. It is combinational, so no latency is added to the data path.

Top module: `pol_corr_ctrl`

## Requirements
- R1: After reset the mode is automatic, `reg_rdata_o` reads 2'b00 and `rx_data_o` equals `rx_raw_i`.
- R2: Register bit 1 is the mode: 0 selects automatic and 1 selects manual. A write sets it from `reg_wdata_i[1]`, and it reads back on `reg_rdata_o[1]` in the next cycle.
- R3: In automatic mode, an observation is a cycle in which `lp_i` or `eof_i` is high. It reports "inverted" when `rx_raw_i` is 0 in that cycle. When CONFIRM consecutive observations (default 3) disagree with the current decision, the decision flips on the clock edge of the last one. An observation that agrees with the current decision clears the run.
- R4: While `frame_active_i` is high, markers are ignored. The automatic decision and the run count do not change.
- R5: While `link_ok_i` is low, the automatic decision returns to non-inverted and the run count clears.
- R6: In automatic mode, `reg_rdata_o[0]` shows the automatic decision (1 means inverted). A write with `reg_wdata_i[1]`=0 does not store `reg_wdata_i[0]`.
- R7: A write with `reg_wdata_i[1]`=1 stores `reg_wdata_i[0]` as the forced polarity. In manual mode, `reg_rdata_o[0]` reads the forced value and that value alone sets the inversion.
- R8: `rx_data_o` equals `rx_raw_i` XOR the effective polarity in the same cycle. The effective polarity is the forced bit in manual mode and the automatic decision otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| link_ok_i | input | 1 | Link is up; low clears the automatic decision |
| frame_active_i | input | 1 | A frame is being received; freezes the decision |
| lp_i | input | 1 | Link pulse marker from the slicer |
| eof_i | input | 1 | End-of-frame idle pulse marker from the slicer |
| rx_raw_i | input | 1 | Sliced receive bit before correction |
| rx_data_o | output | 1 | Corrected receive bit for the Manchester decoder |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 2 | Write data: [1] mode, [0] forced polarity |
| reg_rdata_o | output | 2 | Read data: [1] mode, [0] detected or forced polarity |

## Verification
The bench sweeps every five-observation pattern from a clean state. This exposes an off-by-one in the confirmation count, which would flip after two or four inverted pulses, and a run that is not cleared by an agreeing pulse, which would flip on scattered inversions. Inverted markers are also sent during a frame; a design that does not hold its decision would flip in the middle of a frame. Link loss after a flip must restore the non-inverted state, or the next link partner starts with a stale inversion. All four write values are tried in both modes, which catches a design that lets a write in automatic mode alter the forced bit or that reads the wrong source in either mode.

// File: rtl/pol_corr_pkg.sv
package pol_corr_pkg;

    localparam int REG_W  = 2;
    localparam int MODE_B = 1;
    localparam int POL_B  = 0;

    typedef struct packed {
        logic manual;
        logic forced;
    } pol_cfg_t;

endpackage

// File: rtl/pol_corr_detect.sv
module pol_corr_detect #(
    parameter int CONFIRM = 3
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic link_ok_i,
    input  logic frame_active_i,
    input  logic lp_i,
    input  logic eof_i,
    input  logic rx_raw_i,
    output logic inv_o
);
    localparam int CW = (CONFIRM < 2) ? 1 : $clog2(CONFIRM);
    localparam logic [CW-1:0] LAST = CW'(CONFIRM - 1);

    typedef struct packed {
        logic          inv;
        logic [CW-1:0] cnt;
    } det_t;

    det_t det_d, det_q;
    logic take;
    logic seen_inv;

    always_comb begin
        det_d    = det_q;
        take     = (lp_i | eof_i) & link_ok_i & ~frame_active_i;
        seen_inv = ~rx_raw_i;
        if (!link_ok_i) begin
            det_d = '0;
        end else if (take) begin
            if (seen_inv != det_q.inv) begin
                if (det_q.cnt == LAST) begin
                    det_d.inv = ~det_q.inv;
                    det_d.cnt = '0;
                end else begin
                    det_d.cnt = det_q.cnt + 1'b1;
                end
            end else begin
                det_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) det_q <= '0;
        else         det_q <= det_d;
    end

    assign inv_o = det_q.inv;

    assert_hold_in_frame_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frame_active_i && link_ok_i) |=> ($stable(det_q.inv) && $stable(det_q.cnt)));

    assert_link_loss_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !link_ok_i |=> (det_q.inv == 1'b0 && det_q.cnt == '0));

    assert_flip_needs_marker_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (link_ok_i && !lp_i && !eof_i) |=> $stable(det_q.inv));

    assert_cnt_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        det_q.cnt <= LAST);

endmodule

// File: rtl/pol_corr_regs.sv
module pol_corr_regs
    import pol_corr_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic             auto_inv_i,
    output logic [REG_W-1:0] rdata_o,
    output logic             inv_eff_o
);
    pol_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_i) begin
            cfg_d.manual = wdata_i[MODE_B];
            if (wdata_i[MODE_B]) cfg_d.forced = wdata_i[POL_B];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    assign inv_eff_o       = cfg_q.manual ? cfg_q.forced : auto_inv_i;
    assign rdata_o[MODE_B] = cfg_q.manual;
    assign rdata_o[POL_B]  = inv_eff_o;

    assert_auto_write_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && !wdata_i[MODE_B]) |=> $stable(cfg_q.forced));

    assert_manual_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && wdata_i[MODE_B]) |=> (cfg_q.manual && cfg_q.forced == $past(wdata_i[POL_B])));

    assert_no_write_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_i |=> $stable(cfg_q.manual));

endmodule

// File: rtl/pol_corr_ctrl.sv
module pol_corr_ctrl
    import pol_corr_pkg::*;
#(
    parameter int CONFIRM = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             link_ok_i,
    input  logic             frame_active_i,
    input  logic             lp_i,
    input  logic             eof_i,
    input  logic             rx_raw_i,
    output logic             rx_data_o,
    input  logic             reg_wr_i,
    input  logic [REG_W-1:0] reg_wdata_i,
    output logic [REG_W-1:0] reg_rdata_o
);
    logic auto_inv;
    logic inv_eff;

    pol_corr_detect #(.CONFIRM(CONFIRM)) detect_i (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .link_ok_i      (link_ok_i),
        .frame_active_i (frame_active_i),
        .lp_i           (lp_i),
        .eof_i          (eof_i),
        .rx_raw_i       (rx_raw_i),
        .inv_o          (auto_inv)
    );

    pol_corr_regs regs_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_i       (reg_wr_i),
        .wdata_i    (reg_wdata_i),
        .auto_inv_i (auto_inv),
        .rdata_o    (reg_rdata_o),
        .inv_eff_o  (inv_eff)
    );

    assign rx_data_o = rx_raw_i ^ inv_eff;

    assert_manual_ignores_detector_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_rdata_o[MODE_B] && !reg_wr_i) |=> $stable(reg_rdata_o[POL_B]));

endmodule

// File: tb/pol_corr_ctrl_tb_top.sv
module pol_corr_ctrl_tb_top;
    localparam int CONF = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic link_ok = 1'b0, frame_act = 1'b0, lp = 1'b0, eof = 1'b0, raw = 1'b0;
    logic wr = 1'b0;
    logic [1:0] wdata = 2'b00;
    logic rx_data;
    logic [1:0] rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference state kept from the requirements
    bit m_manual = 0, m_forced = 0, m_auto = 0;
    int m_cnt = 0;

    always #5 clk = ~clk;

    pol_corr_ctrl #(.CONFIRM(CONF)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .link_ok_i(link_ok), .frame_active_i(frame_act),
        .lp_i(lp), .eof_i(eof), .rx_raw_i(raw), .rx_data_o(rx_data),
        .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata)
    );

    task automatic chk(input string req, input logic [1:0] got, input logic [1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // R8 and R6/R7 readback: check register view and both data polarities
    task automatic check_state(input string req);
        bit eff;
        eff = m_manual ? m_forced : m_auto;
        chk(req, rdata, {m_manual, eff});
        for (int v = 0; v < 2; v++) begin
            raw = v[0];
            #1;
            chk({req, "/R8"}, {1'b0, rx_data}, {1'b0, v[0] ^ eff});
        end
        raw = 1'b0;
    endtask

    task automatic observe(input bit use_eof, input bit lvl);
        lp = !use_eof; eof = use_eof; raw = lvl;
        tick();
        lp = 0; eof = 0;
        if (link_ok && !frame_act) begin
            if (bit'(~lvl) != m_auto) begin
                if (m_cnt == CONF - 1) begin m_auto = !m_auto; m_cnt = 0; end
                else m_cnt++;
            end else m_cnt = 0;
        end
    endtask

    task automatic write_reg(input logic [1:0] v);
        wr = 1; wdata = v;
        tick();
        wr = 0;
        m_manual = v[1];
        if (v[1]) m_forced = v[0];
    endtask

    task automatic drop_link();
        link_ok = 0;
        tick();
        link_ok = 1;
        m_auto = 0; m_cnt = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_state("R1");
        link_ok = 1;
        tick();

        // R3: exactly CONF inverted pulses flip, CONF-1 do not
        for (int i = 0; i < CONF; i++) begin
            observe(i[0], 1'b0);
            check_state("R3");
        end
        // R3: flip back needs CONF normal pulses, agreeing one clears run
        observe(0, 1'b1); observe(0, 1'b1); observe(1, 1'b0); check_state("R3");
        observe(0, 1'b1); observe(0, 1'b1); check_state("R3");
        observe(1, 1'b1); check_state("R3");

        // R5: link loss restores non-inverted
        drop_link();
        for (int i = 0; i < CONF; i++) observe(0, 1'b0);
        check_state("R5 pre");
        drop_link();
        check_state("R5");

        // R3 sweep: all five-pulse patterns from a clean state
        for (int p = 0; p < 32; p++) begin
            drop_link();
            for (int b = 0; b < 5; b++) observe(b[0], p[b]);
            check_state("R3 sweep");
        end

        // R4: frame in progress freezes the decision
        drop_link();
        frame_act = 1;
        for (int i = 0; i < CONF + 2; i++) observe(i[0], 1'b0);
        check_state("R4");
        frame_act = 0;
        observe(0, 1'b0);
        check_state("R4 run cleared");

        // R2/R6/R7: every write value from both auto decisions
        for (int a = 0; a < 2; a++) begin
            drop_link();
            if (a == 1) for (int i = 0; i < CONF; i++) observe(0, 1'b0);
            for (int w = 0; w < 4; w++) begin
                write_reg(2'(w));
                check_state(w[1] ? "R7" : "R6");
                write_reg(2'b00);
                check_state("R2");
            end
        end

        // R7: manual mode ignores the detector
        write_reg(2'b11);
        drop_link();
        for (int i = 0; i < CONF; i++) observe(0, 1'b1);
        check_state("R7 hold");
        write_reg(2'b01);
        check_state("R6 back to auto");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule